// File: doc/BRIEF.md
# Multi-Cycle Unsigned Multiply-High Execution Unit

This execution unit receives a 32-bit instruction word and two 64-bit operand values through a start handshake. It decodes the word, and if it names the unsigned multiply-high-doubleword operation, it forms the upper 64 bits of the full 128-bit unsigned product with a radix-2 shift-add engine. The engine runs one partial-product step per clock for 64 steps. When it finishes, the unit presents the destination register index and the result. For the record form it also presents a 4-bit condition field with its write enable.

The unit is placed beside the register file of a larger core. The core's issue logic sees `busy_o` and holds the unit's operands. A start request made while the unit is busy is dropped. An instruction word the unit does not support gives a single-cycle error pulse, and no multiply starts.

Top module: `mulhi_unit`

## Requirements
- R1: When `start_i` is high and `busy_o` is low on a clock edge, the unit accepts the word if `insn_i[31:26]` equals 31 and `insn_i[9:1]` equals 9. `busy_o` is then high in the next cycle.
- R2: When the unit is not busy and a start carries any other value of `insn_i[31:26]` or `insn_i[9:1]`, `err_o` is high for exactly the next cycle. `busy_o` and `done_o` stay low for that start.
- R3: The overflow-enable bit `insn_i[10]` has no effect. A word with that bit set is accepted and gives the same result.
- R4: `result_o` equals bits 127..64 of the product of the two operands, each zero-extended to 128 bits. The unit has no overflow output.
- R5: `done_o` goes high for exactly one cycle, 64 clock edges after the accepting edge. `busy_o` stays high in every cycle between the accept and `done_o`, and is low in the cycle where `done_o` is high.
- R6: A start request made while `busy_o` is high, including in the last busy cycle, is ignored. A start in the cycle where `done_o` is high is accepted.
- R7: While `done_o` is high, `dest_o` shows `insn_i[25:21]` of the accepted word.
- R8: When the accepted word has `insn_i[0]` = 1, `cr_we_o` is high together with `done_o`. In that cycle `cr_o[3]` is result bit 63, `cr_o[2]` is set for a nonzero result with bit 63 clear, and `cr_o[1]` is set for a zero result.
- R9: When `cr_we_o` is high, `cr_o[0]` equals the value `xer_so_i` had on the accepting edge.
- R10: When the accepted word has `insn_i[0]` = 0, `cr_we_o` stays low and `cr_o` reads zero.
- R11: After reset, `busy_o`, `done_o`, `err_o` and `cr_we_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start request |
| insn_i | input | 32 | Instruction word |
| src_a_i | input | 64 | First operand value |
| src_b_i | input | 64 | Second operand value |
| xer_so_i | input | 1 | Sticky summary-overflow flag |
| busy_o | output | 1 | Multiply in progress |
| done_o | output | 1 | One-cycle completion pulse |
| dest_o | output | 5 | Destination register index |
| result_o | output | 64 | High half of the product |
| cr_we_o | output | 1 | Condition-field write enable |
| cr_o | output | 4 | Condition field {LT, GT, EQ, SO} |
| err_o | output | 1 | Unsupported-encoding pulse |

## Verification
Two functions can meet in the same cycle: the completion of one multiply and the start request for the next. The bench provokes this in two ways. In one, a start carrying different operands is held in the last busy cycle, and the bench judges that it was ignored by checking that the result still belongs to the first operands. In the other, a start is held in the cycle where `done_o` is high, and the bench judges that it was accepted by seeing `busy_o` rise and a second correct result arrive. An unsupported word given during the busy window is checked in the same way: it must give no error pulse.

// File: rtl/mhu_pkg.sv
package mhu_pkg;
    localparam int INSN_W = 32;
    localparam int REG_W  = 5;
    localparam logic [5:0] PRIMARY_OP  = 6'd31;
    localparam logic [8:0] EXTENDED_OP = 9'd9;

    typedef struct packed {
        logic [REG_W-1:0] rt;
        logic             oe;
        logic             rc;
        logic             legal;
    } dec_t;

    typedef struct packed {
        logic lt;
        logic gt;
        logic eq;
        logic so;
    } crf_t;

    // Bit 0 is the MSB of the word, so field bit k sits at insn[31-k].
    function automatic dec_t decode_word(input logic [INSN_W-1:0] w);
        dec_t d;
        d.rt    = w[25:21];
        d.oe    = w[10];
        d.rc    = w[0];
        d.legal = (w[31:26] == PRIMARY_OP) && (w[9:1] == EXTENDED_OP);
        return d;
    endfunction
endpackage

// File: rtl/mhu_decode.sv
module mhu_decode
    import mhu_pkg::*;
(
    input  logic [INSN_W-1:0] insn_i,
    output dec_t              dec_o
);
    always_comb dec_o = decode_word(insn_i);
endmodule

// File: rtl/mhu_shiftadd.sv
module mhu_shiftadd #(
    parameter int W = 64
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load_i,
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    output logic         busy_o,
    output logic         done_o,
    output logic [W-1:0] hi_o
);
    localparam int CNT_W = $clog2(W + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(W - 1);

    logic [W-1:0]     mcand_q, mplier_q, acc_q;
    logic [CNT_W-1:0] cnt_q;
    logic             busy_q, done_q;
    logic [W:0]       sum;
    logic [2*W-1:0]   step;

    always_comb begin
        sum  = {1'b0, acc_q} + (mplier_q[0] ? {1'b0, mcand_q} : '0);
        step = {sum, mplier_q[W-1:1]};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q   <= 1'b0;
            done_q   <= 1'b0;
            cnt_q    <= '0;
            acc_q    <= '0;
            mcand_q  <= '0;
            mplier_q <= '0;
        end else begin
            done_q <= 1'b0;
            if (busy_q) begin
                acc_q    <= step[2*W-1:W];
                mplier_q <= step[W-1:0];
                cnt_q    <= cnt_q + 1'b1;
                if (cnt_q == LAST) begin
                    busy_q <= 1'b0;
                    done_q <= 1'b1;
                end
            end else if (load_i) begin
                mcand_q  <= a_i;
                mplier_q <= b_i;
                acc_q    <= '0;
                cnt_q    <= '0;
                busy_q   <= 1'b1;
            end
        end
    end

    assign busy_o = busy_q;
    assign done_o = done_q;
    assign hi_o   = acc_q;

    AST_DONE_FOLLOWS_BUSY: assert property (@(posedge clk) disable iff (rst)
        done_q |-> $past(busy_q)); // R5
    AST_BUSY_DONE_EXCL: assert property (@(posedge clk) disable iff (rst)
        $onehot0({busy_q, done_q})); // R5
    AST_LOAD_WHILE_BUSY: assert property (@(posedge clk) disable iff (rst)
        (busy_q && load_i) |=> (busy_q || done_q)); // R6
endmodule

// File: rtl/mhu_cond.sv
module mhu_cond
    import mhu_pkg::*;
#(
    parameter int W = 64
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         en_i,
    input  logic [W-1:0] res_i,
    input  logic         so_i,
    output crf_t         crf_o
);
    always_comb begin
        crf_o = '0;
        if (en_i) begin
            crf_o.lt = res_i[W-1];
            crf_o.eq = (res_i == '0);
            crf_o.gt = !res_i[W-1] && (res_i != '0);
            crf_o.so = so_i;
        end
    end

    AST_CR_ONE_RELATION: assert property (@(posedge clk) disable iff (rst)
        en_i |-> $onehot({crf_o.lt, crf_o.gt, crf_o.eq})); // R8
    AST_CR_QUIET: assert property (@(posedge clk) disable iff (rst)
        !en_i |-> (crf_o == '0)); // R10
endmodule

// File: rtl/mulhi_unit.sv
module mulhi_unit
    import mhu_pkg::*;
#(
    parameter int DATA_W = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic [31:0]       insn_i,
    input  logic [DATA_W-1:0] src_a_i,
    input  logic [DATA_W-1:0] src_b_i,
    input  logic              xer_so_i,
    output logic              busy_o,
    output logic              done_o,
    output logic [4:0]        dest_o,
    output logic [DATA_W-1:0] result_o,
    output logic              cr_we_o,
    output logic [3:0]        cr_o,
    output logic              err_o
);
    dec_t             dec;
    logic             mul_busy, mul_done, accept, launch;
    logic [4:0]       rt_q;
    logic             rc_q, so_q, err_q;
    logic [DATA_W-1:0] hi;
    crf_t             crf;

    mhu_decode u_dec (.insn_i(insn_i), .dec_o(dec));

    assign accept = start_i && !mul_busy;
    assign launch = accept && dec.legal;

    mhu_shiftadd #(.W(DATA_W)) u_mul (
        .clk(clk), .rst(rst), .load_i(launch),
        .a_i(src_a_i), .b_i(src_b_i),
        .busy_o(mul_busy), .done_o(mul_done), .hi_o(hi)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rt_q  <= '0;
            rc_q  <= 1'b0;
            so_q  <= 1'b0;
            err_q <= 1'b0;
        end else begin
            err_q <= accept && !dec.legal;
            if (launch) begin
                rt_q <= dec.rt;
                rc_q <= dec.rc;
                so_q <= xer_so_i;
            end
        end
    end

    mhu_cond #(.W(DATA_W)) u_cond (
        .clk(clk), .rst(rst), .en_i(mul_done && rc_q),
        .res_i(hi), .so_i(so_q), .crf_o(crf)
    );

    assign busy_o   = mul_busy;
    assign done_o   = mul_done;
    assign dest_o   = rt_q;
    assign result_o = hi;
    assign cr_we_o  = mul_done && rc_q;
    assign cr_o     = crf;
    assign err_o    = err_q;

    AST_BUSY_NEEDS_START: assert property (@(posedge clk) disable iff (rst)
        $rose(busy_o) |-> $past(start_i)); // R1
    AST_ERR_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        err_o |-> !(busy_o || done_o)); // R2
    AST_CRWE_WITH_DONE: assert property (@(posedge clk) disable iff (rst)
        cr_we_o |-> done_o); // R8
endmodule

// File: tb/mulhi_unit_tb.sv
`timescale 1ns/1ps
module mulhi_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start_i = 1'b0;
    logic [31:0] insn_i = '0;
    logic [63:0] src_a_i = '0, src_b_i = '0;
    logic        xer_so_i = 1'b0;
    logic        busy_o, done_o, cr_we_o, err_o;
    logic [4:0]  dest_o;
    logic [63:0] result_o;
    logic [3:0]  cr_o;

    int checks = 0;
    int fails = 0;
    bit finished = 0;
    logic [63:0] rng = 64'h9E37_79B9_7F4A_7C15;

    always #2.5 clk = ~clk;

    mulhi_unit dut_i (.*);

    function automatic logic [31:0] mk_word(input logic [5:0] prim, input logic [4:0] rt,
                                            input logic oe, input logic [8:0] xo, input logic rc);
        return {prim, rt, 5'd3, 5'd4, oe, xo, rc};
    endfunction

    function automatic logic [63:0] ref_hi(input logic [63:0] a, input logic [63:0] b);
        logic [127:0] p;
        p = {64'd0, a} * {64'd0, b};
        return p[127:64];
    endfunction

    function automatic logic [3:0] ref_cr(input logic [63:0] r, input logic so);
        return {r[63], (!r[63] && r != 0), (r == 0), so};
    endfunction

    function automatic logic [63:0] next_rand();
        rng ^= rng << 13;
        rng ^= rng >> 7;
        rng ^= rng << 17;
        return rng;
    endfunction

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // poke: 0 none, 1 late start in last busy cycle, 2 illegal start mid-run,
    // 3 start in done cycle (chained)
    task automatic run_op(input logic [31:0] w, input logic [63:0] a, input logic [63:0] b,
                          input logic so, input int poke);
        int k;
        logic [63:0] eh;
        @(negedge clk);
        insn_i = w; src_a_i = a; src_b_i = b; xer_so_i = so; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0; xer_so_i = ~so;
        src_a_i = next_rand(); src_b_i = next_rand();
        check(busy_o === 1'b1, "R1 busy after accept", 64'(busy_o), 64'd1);
        k = 0;
        while (!done_o && k < 100) begin
            if (poke == 1 && k == 63) begin
                insn_i = mk_word(6'd31, 5'd9, 1'b0, 9'd9, 1'b1); start_i = 1'b1;
            end
            if (poke == 2 && k == 30) begin
                insn_i = mk_word(6'd30, 5'd9, 1'b0, 9'd9, 1'b0); start_i = 1'b1;
            end
            if (poke == 2 && k == 31) begin
                start_i = 1'b0;
                check(err_o === 1'b0, "R6 illegal start while busy ignored", 64'(err_o), 64'd0);
            end
            if (k > 0 && k < 64)
                check(busy_o === 1'b1, "R5 busy held", 64'(busy_o), 64'd1);
            @(negedge clk);
            k++;
        end
        start_i = 1'b0;
        eh = ref_hi(a, b);
        check(k == 64, "R5 latency", 64'(k), 64'd64);
        check(busy_o === 1'b0, "R5 busy low at done", 64'(busy_o), 64'd0);
        check(result_o === eh, "R4 high half", result_o, eh);
        check(dest_o === w[25:21], "R7 destination", 64'(dest_o), 64'(w[25:21]));
        if (w[0]) begin
            check(cr_we_o === 1'b1, "R8 cr write", 64'(cr_we_o), 64'd1);
            check(cr_o[3:1] === ref_cr(eh, so)[3:1], "R8 LT/GT/EQ", 64'(cr_o), 64'(ref_cr(eh, so)));
            check(cr_o[0] === so, "R9 summary overflow", 64'(cr_o[0]), 64'(so));
        end else begin
            check(cr_we_o === 1'b0 && cr_o === 4'd0, "R10 no cr write", 64'({cr_we_o, cr_o}), 64'd0);
        end
        if (poke == 3) begin
            insn_i = mk_word(6'd31, 5'd17, 1'b0, 9'd9, 1'b1);
            src_a_i = 64'hFFFF_FFFF_FFFF_FFFF; src_b_i = 64'h2; xer_so_i = 1'b1; start_i = 1'b1;
            @(negedge clk);
            start_i = 1'b0;
            check(busy_o === 1'b1, "R6 start in done cycle accepted", 64'(busy_o), 64'd1);
            k = 0;
            while (!done_o && k < 100) begin @(negedge clk); k++; end
            check(k == 64 && result_o === 64'd1, "R6 chained result", result_o, 64'd1);
            check(cr_o === 4'b0101, "R8 R9 chained cr GT+SO", 64'(cr_o), 64'b0101);
        end
        @(negedge clk);
        check(done_o === 1'b0, "R5 done is one cycle", 64'(done_o), 64'd0);
    endtask

    task automatic run_illegal(input logic [31:0] w);
        @(negedge clk);
        insn_i = w; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        check(err_o === 1'b1 && busy_o === 1'b0, "R2 error pulse", 64'({err_o, busy_o}), 64'b10);
        @(negedge clk);
        check(err_o === 1'b0 && done_o === 1'b0, "R2 error one cycle", 64'({err_o, done_o}), 64'd0);
    endtask

    initial begin
        #(5.0 * 150000);
        if (!finished) begin
            checks++; fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check({busy_o, done_o, err_o, cr_we_o} === 4'd0, "R11 reset state",
              64'({busy_o, done_o, err_o, cr_we_o}), 64'd0);

        // corner operands
        run_op(mk_word(6'd31, 5'd1, 1'b0, 9'd9, 1'b1), '1, '1, 1'b0, 0);
        run_op(mk_word(6'd31, 5'd2, 1'b0, 9'd9, 1'b1), 64'd0, '1, 1'b1, 0);
        run_op(mk_word(6'd31, 5'd3, 1'b0, 9'd9, 1'b1), 64'd12345, 64'd678, 1'b0, 0);
        run_op(mk_word(6'd31, 5'd4, 1'b0, 9'd9, 1'b1), 64'h8000_0000_0000_0000, '1, 1'b1, 0);
        run_op(mk_word(6'd31, 5'd5, 1'b0, 9'd9, 1'b0), 64'd0, 64'd0, 1'b1, 0);
        // R3: OE bit set, same result expected
        run_op(mk_word(6'd31, 5'd6, 1'b1, 9'd9, 1'b1), '1, '1, 1'b0, 0);
        run_op(mk_word(6'd31, 5'd31, 1'b1, 9'd9, 1'b0), 64'hDEAD_BEEF_0123_4567, 64'hFEDC_BA98_7654_3210, 1'b0, 0);
        // R6 probes
        run_op(mk_word(6'd31, 5'd7, 1'b0, 9'd9, 1'b1), 64'h1_0000_0000, 64'h3_0000_0000, 1'b0, 1);
        run_op(mk_word(6'd31, 5'd8, 1'b0, 9'd9, 1'b0), 64'hAAAA_AAAA_AAAA_AAAA, 64'h5555_5555_5555_5555, 1'b0, 2);
        run_op(mk_word(6'd31, 5'd10, 1'b0, 9'd9, 1'b1), 64'h10, 64'h20, 1'b0, 3);

        // swept masks
        for (int i = 0; i < 64; i += 7)
            for (int j = 0; j < 64; j += 7)
                run_op(mk_word(6'd31, 5'(i + j), 1'(j), 9'd9, 1'(i)), '1 >> i, '1 << j, 1'(i + j), 0);

        // pseudo-random operands
        for (int n = 0; n < 40; n++) begin
            logic [63:0] ra, rb;
            ra = next_rand(); rb = next_rand();
            run_op(mk_word(6'd31, 5'(n), 1'(n >> 1), 9'd9, 1'(n)), ra, rb, 1'(n >> 2), 0);
        end

        // R2: every other primary opcode, then every other extended opcode
        for (int p = 0; p < 64; p++)
            if (p != 31) run_illegal(mk_word(6'(p), 5'd1, 1'b0, 9'd9, 1'b0));
        for (int x = 0; x < 512; x++)
            if (x != 9) run_illegal(mk_word(6'd31, 5'd1, 1'(x), 9'(x), 1'(x >> 1)));

        finished = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule